// File: doc/BRIEF.md
# Sound Generator Host Register Bank

This block sits between a host bus and the voice logic of a three-channel sound generator. The host uses two control lines to pick one of four bus functions per clock: idle, read, write, or address capture. An address-capture cycle loads a register pointer from the 8-bit data bus. Later read and write cycles act on the register that pointer selects.

The bank has sixteen 8-bit registers. They are named in octal, R0 through R17. Each register keeps only the bits that are defined for it, and every register can be read back. The stored contents are decoded into fields and sent continuously to the tone, noise, mixer, amplitude and envelope logic. Writing the envelope shape register raises a restart strobe for one clock.

Two registers drive general-purpose 8-bit ports. A direction bit in the mixer register controls each one. A port set to input reads back its pins, and a port set to output reads back its stored byte. Reset puts the bank in a silent state with both ports set to input.

Top module: `psg_regbank`

## Requirements
- R1: The pair (`bus_dir`, `bus_ctl`) selects the function: 00 = idle, 01 = read, 10 = write, 11 = address capture. `data_oe` is 1 only during a read. `data_out` is 0 whenever `data_oe` is 0.
- R2: An address capture stores `data_in[3:0]` as the register pointer. If `data_in[7:4]` is not zero, the pointer selects no register: writes change nothing, and reads return 0 with `data_oe` high.
- R3: An active-low synchronous reset (`rst_n`) clears every register to 0x00 except R7, which becomes 0xFF. It also clears the pointer to R0 (valid) and clears the strobe.
- R4: R0, R2 and R4 keep all 8 bits. R1, R3 and R5 keep bits 3:0 only. The tone periods are {R1[3:0],R0}, {R3[3:0],R2} and {R5[3:0],R4} for voices A, B and C.
- R5: R6 keeps bits 4:0, and these bits form `noise_period`.
- R6: R10, R11 and R12 keep bits 4:0. Each one appears on its own amplitude output: bit 4 selects envelope mode and bits 3:0 give the fixed level.
- R7: The envelope period is {R14,R13} (16 bits). R15 keeps bits 3:0, and these bits form `env_shape`.
- R8: A write to R15 (pointer value 13) drives `env_restart` high for exactly the clock cycle after the write edge. Writes to any other register leave it low.
- R9: R7 bits 2:0 are the tone-disable flags for voices A, B and C. Bits 5:3 are the noise-disable flags for the same voices. A 1 mutes.
- R10: R7 bit 7 sets the direction of port A (R16, pointer 14), and bit 6 sets the direction of port B (R17, pointer 15). A value of 0 means output, which sets `port_x_drive` to 1. A read of a port that is set to input returns its pins. A read of a port that is set to output returns the stored byte.
- R11: Idle, read and address-capture cycles leave every register, and so every exported field, unchanged.
- R12: Every register reads back its written value ANDed with its keep-mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_dir | input | 1 | Bus control line, direction |
| bus_ctl | input | 1 | Bus control line, function |
| data_in | input | 8 | Host write data or address |
| data_out | output | 8 | Read data |
| data_oe | output | 1 | Read data is being driven |
| port_a_pins | input | 8 | External pin levels of port A |
| port_b_pins | input | 8 | External pin levels of port B |
| port_a_out | output | 8 | Stored port A byte |
| port_b_out | output | 8 | Stored port B byte |
| port_a_drive | output | 1 | Port A set to output |
| port_b_drive | output | 1 | Port B set to output |
| tone_a_period | output | 12 | Voice A tone period |
| tone_b_period | output | 12 | Voice B tone period |
| tone_c_period | output | 12 | Voice C tone period |
| noise_period | output | 5 | Noise period |
| tone_off | output | 3 | Tone mute flags, C B A |
| noise_off | output | 3 | Noise mute flags, C B A |
| amp_a | output | 5 | Voice A amplitude control |
| amp_b | output | 5 | Voice B amplitude control |
| amp_c | output | 5 | Voice C amplitude control |
| env_period | output | 16 | Envelope period |
| env_shape | output | 4 | Envelope shape bits |
| env_restart | output | 1 | One-cycle envelope restart strobe |

## Verification
The bench writes all-ones to every register and reads them back. A mask applied to the wrong register shows up here as a stray high bit in a coarse-tune, noise, amplitude or shape read. It then captures an out-of-range address (0x25), writes to it and reads from it. A design that decoded only the low nibble would corrupt R5 and return R5's contents instead of zero. The bench flips each port's direction bit separately. A swapped bit 6/7 mapping, or a wrongly inverted sense, would return stored data where pin levels are expected, or the reverse. The envelope strobe is sampled one cycle after the R15 write and one cycle later again, and after a write to a neighbouring register. A strobe that lingers, or one decoded on the wrong pointer, fails these checks.

// File: rtl/psg_regbank_pkg.sv
package psg_regbank_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 16;
    localparam int ADDR_W   = $clog2(NUM_REGS);
    localparam int TONE_W   = 12;
    localparam int NOISE_W  = 5;
    localparam int AMP_W    = 5;
    localparam int SHAPE_W  = 4;
    localparam int VOICES   = 3;

    // register indices (decimal pointer values)
    localparam int IDX_TONE_A_LO = 0;
    localparam int IDX_NOISE     = 6;
    localparam int IDX_MIXER     = 7;
    localparam int IDX_AMP_A     = 8;
    localparam int IDX_ENV_LO    = 11;
    localparam int IDX_ENV_HI    = 12;
    localparam int IDX_SHAPE     = 13;
    localparam int IDX_PORT_A    = 14;
    localparam int IDX_PORT_B    = 15;

    // direction bits inside the mixer register
    localparam int DIR_BIT_A = 7;
    localparam int DIR_BIT_B = 6;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'b00,
        BUS_READ  = 2'b01,
        BUS_WRITE = 2'b10,
        BUS_LATCH = 2'b11
    } bus_op_e;

    typedef logic [NUM_REGS-1:0][DATA_W-1:0] reg_file_t;

    typedef struct packed {
        reg_file_t         regs;
        logic [ADDR_W-1:0] sel;
        logic              sel_ok;
        logic              strobe;
    } bank_state_t;

    function automatic logic [DATA_W-1:0] keep_mask(input int idx);
        logic [DATA_W-1:0] m;
        case (idx)
            1, 3, 5:        m = DATA_W'((1 << 4) - 1);
            IDX_NOISE:      m = DATA_W'((1 << NOISE_W) - 1);
            8, 9, 10:       m = DATA_W'((1 << AMP_W) - 1);
            IDX_SHAPE:      m = DATA_W'((1 << SHAPE_W) - 1);
            default:        m = '1;
        endcase
        return m;
    endfunction

    function automatic bank_state_t reset_state();
        bank_state_t s;
        s.regs            = '0;
        s.regs[IDX_MIXER] = '1;
        s.sel             = '0;
        s.sel_ok          = 1'b1;
        s.strobe          = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/psg_bus_decode.sv
module psg_bus_decode
    import psg_regbank_pkg::*;
(
    input  logic    bus_dir,
    input  logic    bus_ctl,
    output bus_op_e op
);
    always_comb begin
        case ({bus_dir, bus_ctl})
            2'b01:   op = BUS_READ;
            2'b10:   op = BUS_WRITE;
            2'b11:   op = BUS_LATCH;
            default: op = BUS_IDLE;
        endcase
    end
endmodule

// File: rtl/psg_reg_store.sv
module psg_reg_store
    import psg_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_e           op,
    input  logic [DATA_W-1:0] data_in,
    output reg_file_t         regs,
    output logic [ADDR_W-1:0] sel,
    output logic              sel_ok,
    output logic              strobe
);
    bank_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        case (op)
            BUS_LATCH: begin
                st_d.sel    = data_in[ADDR_W-1:0];
                st_d.sel_ok = (data_in[DATA_W-1:ADDR_W] == '0);
            end
            BUS_WRITE: begin
                if (st_q.sel_ok) begin
                    for (int i = 0; i < NUM_REGS; i++) begin
                        if (st_q.sel == ADDR_W'(i))
                            st_d.regs[i] = data_in & keep_mask(i);
                    end
                    st_d.strobe = (st_q.sel == ADDR_W'(IDX_SHAPE));
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign regs   = st_q.regs;
    assign sel    = st_q.sel;
    assign sel_ok = st_q.sel_ok;
    assign strobe = st_q.strobe;
endmodule

// File: rtl/psg_read_mux.sv
module psg_read_mux
    import psg_regbank_pkg::*;
(
    input  bus_op_e           op,
    input  reg_file_t         regs,
    input  logic [ADDR_W-1:0] sel,
    input  logic              sel_ok,
    input  logic [DATA_W-1:0] pins_a,
    input  logic [DATA_W-1:0] pins_b,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    logic [DATA_W-1:0] picked;

    always_comb begin
        picked = regs[sel];
        if (sel == ADDR_W'(IDX_PORT_A) && regs[IDX_MIXER][DIR_BIT_A])
            picked = pins_a;
        if (sel == ADDR_W'(IDX_PORT_B) && regs[IDX_MIXER][DIR_BIT_B])
            picked = pins_b;
        if (!sel_ok)
            picked = '0;
        data_oe  = (op == BUS_READ);
        data_out = data_oe ? picked : '0;
    end
endmodule

// File: rtl/psg_regbank.sv
module psg_regbank
    import psg_regbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_dir,
    input  logic               bus_ctl,
    input  logic [DATA_W-1:0]  data_in,
    output logic [DATA_W-1:0]  data_out,
    output logic               data_oe,
    input  logic [DATA_W-1:0]  port_a_pins,
    input  logic [DATA_W-1:0]  port_b_pins,
    output logic [DATA_W-1:0]  port_a_out,
    output logic [DATA_W-1:0]  port_b_out,
    output logic               port_a_drive,
    output logic               port_b_drive,
    output logic [TONE_W-1:0]  tone_a_period,
    output logic [TONE_W-1:0]  tone_b_period,
    output logic [TONE_W-1:0]  tone_c_period,
    output logic [NOISE_W-1:0] noise_period,
    output logic [VOICES-1:0]  tone_off,
    output logic [VOICES-1:0]  noise_off,
    output logic [AMP_W-1:0]   amp_a,
    output logic [AMP_W-1:0]   amp_b,
    output logic [AMP_W-1:0]   amp_c,
    output logic [2*DATA_W-1:0] env_period,
    output logic [SHAPE_W-1:0] env_shape,
    output logic               env_restart
);
    localparam int COARSE_W = TONE_W - DATA_W;

    bus_op_e           op;
    reg_file_t         regs;
    logic [ADDR_W-1:0] sel;
    logic              sel_ok;

    logic [VOICES-1:0][TONE_W-1:0] tone_vec;
    logic [VOICES-1:0][AMP_W-1:0]  amp_vec;

    psg_bus_decode u_dec (
        .bus_dir (bus_dir),
        .bus_ctl (bus_ctl),
        .op      (op)
    );

    psg_reg_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .data_in (data_in),
        .regs    (regs),
        .sel     (sel),
        .sel_ok  (sel_ok),
        .strobe  (env_restart)
    );

    psg_read_mux u_rd (
        .op       (op),
        .regs     (regs),
        .sel      (sel),
        .sel_ok   (sel_ok),
        .pins_a   (port_a_pins),
        .pins_b   (port_b_pins),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

    for (genvar v = 0; v < VOICES; v++) begin : g_voice
        assign tone_vec[v] = {regs[IDX_TONE_A_LO + 2*v + 1][COARSE_W-1:0],
                              regs[IDX_TONE_A_LO + 2*v]};
        assign amp_vec[v]  = regs[IDX_AMP_A + v][AMP_W-1:0];
    end

    assign tone_a_period = tone_vec[0];
    assign tone_b_period = tone_vec[1];
    assign tone_c_period = tone_vec[2];
    assign amp_a         = amp_vec[0];
    assign amp_b         = amp_vec[1];
    assign amp_c         = amp_vec[2];

    assign noise_period  = regs[IDX_NOISE][NOISE_W-1:0];
    assign tone_off      = regs[IDX_MIXER][VOICES-1:0];
    assign noise_off     = regs[IDX_MIXER][2*VOICES-1:VOICES];
    assign env_period    = {regs[IDX_ENV_HI], regs[IDX_ENV_LO]};
    assign env_shape     = regs[IDX_SHAPE][SHAPE_W-1:0];

    assign port_a_out    = regs[IDX_PORT_A];
    assign port_b_out    = regs[IDX_PORT_B];
    assign port_a_drive  = ~regs[IDX_MIXER][DIR_BIT_A];
    assign port_b_drive  = ~regs[IDX_MIXER][DIR_BIT_B];
endmodule

// File: rtl/psg_regbank_chk.sv
module psg_regbank_chk
    import psg_regbank_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_dir,
    input logic               bus_ctl,
    input logic [DATA_W-1:0]  data_out,
    input logic               data_oe,
    input logic [TONE_W-1:0]  tone_a_period,
    input logic [NOISE_W-1:0] noise_period,
    input logic [VOICES-1:0]  tone_off,
    input logic [VOICES-1:0]  noise_off,
    input logic [2*DATA_W-1:0] env_period,
    input logic [SHAPE_W-1:0] env_shape,
    input logic               env_restart
);
    // R1
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe == (!bus_dir && bus_ctl)) && (!data_oe -> data_out == '0));

    // R11
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_dir && !bus_ctl) |=> $stable(tone_a_period) && $stable(noise_period)
            && $stable(tone_off) && $stable(noise_off) && $stable(env_period)
            && $stable(env_shape));

    // R8
    restart_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        env_restart |-> $past(bus_dir && !bus_ctl));

    // R3
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (tone_off == '1 && noise_off == '1 && env_period == '0
            && !env_restart));
endmodule

bind psg_regbank psg_regbank_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_dir       (bus_dir),
    .bus_ctl       (bus_ctl),
    .data_out      (data_out),
    .data_oe       (data_oe),
    .tone_a_period (tone_a_period),
    .noise_period  (noise_period),
    .tone_off      (tone_off),
    .noise_off     (noise_off),
    .env_period    (env_period),
    .env_shape     (env_shape),
    .env_restart   (env_restart)
);

// File: tb/psg_regbank_tb.sv
module psg_regbank_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_dir = 0, bus_ctl = 0;
    logic [7:0]  data_in = 0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic [7:0]  pins_a = 8'h5A, pins_b = 8'hC3;
    logic [7:0]  port_a_out, port_b_out;
    logic        port_a_drive, port_b_drive;
    logic [11:0] tone_a, tone_b, tone_c;
    logic [4:0]  noise_p;
    logic [2:0]  tone_off, noise_off;
    logic [4:0]  amp_a, amp_b, amp_c;
    logic [15:0] env_p;
    logic [3:0]  env_shape;
    logic        env_restart;

    always #2 clk = ~clk;

    psg_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_dir(bus_dir), .bus_ctl(bus_ctl),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .port_a_pins(pins_a), .port_b_pins(pins_b),
        .port_a_out(port_a_out), .port_b_out(port_b_out),
        .port_a_drive(port_a_drive), .port_b_drive(port_b_drive),
        .tone_a_period(tone_a), .tone_b_period(tone_b), .tone_c_period(tone_c),
        .noise_period(noise_p), .tone_off(tone_off), .noise_off(noise_off),
        .amp_a(amp_a), .amp_b(amp_b), .amp_c(amp_c),
        .env_period(env_p), .env_shape(env_shape), .env_restart(env_restart)
    );

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t q[$];
    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] model [16];

    function automatic logic [7:0] exp_mask(int a);
        if (a == 1 || a == 3 || a == 5 || a == 13) return 8'h0F;
        if (a == 6 || a == 8 || a == 9 || a == 10) return 8'h1F;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] exp_read(int a);
        if (a == 14 && model[7][7]) return pins_a;
        if (a == 15 && model[7][6]) return pins_b;
        return model[a];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic d, logic c, logic [7:0] v);
        bus_dir = d; bus_ctl = c; data_in = v;
        @(posedge clk); #1;
        bus_dir = 0; bus_ctl = 0; data_in = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] v);
        cyc(1, 1, a);
        cyc(1, 0, v);
        if (a < 16) model[a] = v & exp_mask(int'(a));
    endtask

    task automatic rd(logic [7:0] a, string tag);
        item_t it;
        cyc(1, 1, a);
        it.exp = (a < 16) ? exp_read(int'(a)) : 8'h00;
        it.tag = tag;
        q.push_back(it);
        cyc(0, 1, 8'h00);
    endtask

    // monitor: compares each read against the scoreboard
    always @(negedge clk) begin
        if (data_oe) begin
            if (q.size() == 0) chk("R1 unexpected read", 1, 0);
            else begin
                item_t it;
                it = q.pop_front();
                chk(it.tag, data_out, it.exp);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        model[7] = 8'hFF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R3 reset state
        chk("R3 tone_off", tone_off, 3'b111);
        chk("R3 noise_off", noise_off, 3'b111);
        chk("R3 env_p", env_p, 0);
        chk("R10 reset dir A", port_a_drive, 0);
        chk("R1 idle oe", data_oe, 0);
        for (int a = 0; a < 16; a++) rd(8'(a), "R3 reset readback");
        // R12 masks: all ones everywhere except mixer
        for (int a = 0; a < 16; a++) begin
            if (a == 7) continue;
            wr(8'(a), 8'hFF);
            if (a == 13) begin
                chk("R8 strobe high", env_restart, 1);
                @(posedge clk); #1;
                chk("R8 strobe one cycle", env_restart, 0);
            end
        end
        for (int a = 0; a < 16; a++) rd(8'(a), "R12 masked readback");
        // R9/R10 mixer and both ports output
        wr(8'd7, 8'h15);
        chk("R9 tone_off", tone_off, 3'b101);
        chk("R9 noise_off", noise_off, 3'b010);
        chk("R10 drive A", port_a_drive, 1);
        chk("R10 drive B", port_b_drive, 1);
        rd(8'd14, "R10 port A output readback");
        rd(8'd15, "R10 port B output readback");
        // R4..R7 field export
        wr(0, 8'h34); wr(1, 8'hA7); wr(2, 8'h9C); wr(3, 8'h12);
        wr(4, 8'h01); wr(5, 8'hFE); wr(6, 8'hEB); wr(8, 8'h3A);
        wr(9, 8'h05); wr(10, 8'h10);
        wr(11, 8'hCD); wr(12, 8'h8E);
        chk("R8 no strobe other reg", env_restart, 0);
        wr(13, 8'hF6);
        chk("R4 tone A", tone_a, 12'h734);
        chk("R4 tone B", tone_b, 12'h29C);
        chk("R4 tone C", tone_c, 12'hE01);
        chk("R5 noise", noise_p, 5'h0B);
        chk("R6 amp A", amp_a, 5'h1A);
        chk("R6 amp B", amp_b, 5'h05);
        chk("R6 amp C", amp_c, 5'h10);
        chk("R7 env period", env_p, 16'h8ECD);
        chk("R7 env shape", env_shape, 4'h6);
        // R2 out-of-range pointer
        wr(8'h25, 8'h77);
        chk("R2 ignored write", tone_c, 12'hE01);
        rd(8'h25, "R2 out-of-range read");
        rd(8'd5, "R2 R5 untouched");
        // R11 idle/latch cycles
        cyc(1, 1, 8'h03);
        cyc(0, 0, 8'hAA);
        chk("R11 no change", tone_b, 12'h29C);
        // R10 mixed direction: A input, B output
        wr(8'd7, 8'h95);
        pins_a = 8'h3C;
        rd(8'd14, "R10 port A pins");
        rd(8'd15, "R10 port B stored");
        chk("R10 drive A input", port_a_drive, 0);
        chk("R10 drive B output", port_b_drive, 1);
        @(posedge clk); #1;
        chk("R1 read queue drained", q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule